// File: doc/BRIEF.md
# SRAM Write Posting Buffer

This block sits between a processor-side bus and a single-port SRAM with a synchronous read port. It keeps the most recent bus write in a one-entry holding register rather than writing it straight away, so the processor never waits on a write. The held write goes into the SRAM during the cycle in which the next bus write is presented, and that new write then becomes the held entry. A write and the commit of its predecessor share one cycle, which is what keeps back-to-back writes free of wait states.

Bus reads go straight to the SRAM. If the read addresses the word that is being held, the held byte lanes replace the matching lanes of the SRAM word, so the processor always sees its own latest write. A reset empties the holding register and does not commit it. Software that needs a value to survive a reset writes it twice in a row, or follows it with a throwaway write to any other location.

Top module: `sram_post_buffer`

## Requirements
- R1: While reset is asserted the SRAM write enable is low and no read response is signalled, even with the write strobe high.
- R2: A bus write that arrives while a write is held drives the SRAM write enable high in that same cycle. SRAM address, byte enables and data then carry the held write. The new write replaces the held one at the next clock edge.
- R3: A bus write that arrives when nothing is held, such as the first write after reset, leaves the SRAM write enable low.
- R4: Byte enables and lane placement come from size and address. Size 0 is a byte: enable 1<<addr[1:0], and bus data bits 7:0 go to that lane. Size 1 is a halfword: enable 4'b0011 or 4'b1100 chosen by addr[1], with data bits 15:0 in those lanes. Size 2 or 3 is a word: enable 4'b1111 with the data unchanged. Address bits below the access alignment are ignored. The SRAM address is the byte address shifted right by 2.
- R5: A cycle without the write strobe never writes the SRAM.
- R6: A read strobe without the write strobe raises the read-valid output in the next cycle. The read data is then the SRAM word, with each held byte lane substituted when the held write targets the same word.
- R7: A read strobe in the same cycle as a write strobe is ignored: no read-valid follows. The write is handled as in R2/R3.
- R8: A write still held when reset arrives never reaches the SRAM, and a later read of that word returns the old SRAM contents.
- R9: Two identical consecutive writes leave the value in the SRAM, where it survives a reset.
- R10: In a read cycle the SRAM address equals the bus word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8*LANES | Write data, right-aligned |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8*LANES | Read word, lane-aligned |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| sram_addr | output | ADDR_W-2 | SRAM word address |
| sram_wdata | output | 8*LANES | SRAM write data |
| sram_be | output | LANES | SRAM byte-lane enables |
| sram_we | output | 1 | SRAM write enable |
| sram_rdata | input | 8*LANES | SRAM read data, one cycle after the address |

## Verification
The assertions assume the SRAM returns the addressed word one cycle after a non-write cycle, and that a read needing its data never shares a cycle with a write. The bench SRAM model behaves this way, and the stimulus drives simultaneous read and write strobes only when it checks that such a read is dropped. Misaligned addresses are applied on purpose, since the design defines them by ignoring the low address bits.

// File: rtl/spb_pkg.sv
package spb_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;
endpackage

// File: rtl/spb_lane_map.sv
module spb_lane_map #(
   parameter int LANES = 4,
   localparam int DATA_W = 8 * LANES,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] lane_data
);
   import spb_pkg::*;

   acc_size_e sz;
   assign sz = acc_size_e'(size);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(i);
      always_comb begin
         unique case (sz)
            SZ_BYTE: begin
               be[i]             = (off == LANE_IDX);
               lane_data[8*i+:8] = wdata[7:0];
            end
            SZ_HALF: begin
               be[i]             = (off[OFF_W-1:1] == LANE_IDX[OFF_W-1:1]);
               lane_data[8*i+:8] = wdata[8*(i%2)+:8];
            end
            default: begin
               be[i]             = 1'b1;
               lane_data[8*i+:8] = wdata[8*i+:8];
            end
         endcase
      end
   end
endmodule

// File: rtl/spb_hold.sv
module spb_hold #(
   parameter int WAW   = 10,
   parameter int LANES = 4,
   localparam int DATA_W = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAW-1:0]    in_addr,
   input  logic [LANES-1:0]  in_be,
   input  logic [DATA_W-1:0] in_data,
   output logic              held,
   output logic [WAW-1:0]    held_addr,
   output logic [LANES-1:0]  held_be,
   output logic [DATA_W-1:0] held_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_addr <= '0;
         held_be   <= '0;
         held_data <= '0;
      end else if (load) begin
         held      <= 1'b1;
         held_addr <= in_addr;
         held_be   <= in_be;
         held_data <= in_data;
      end
   end
endmodule

// File: rtl/spb_read_merge.sv
module spb_read_merge #(
   parameter int WAW   = 10,
   parameter int LANES = 4,
   localparam int DATA_W = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [WAW-1:0]    rd_addr,
   input  logic              held,
   input  logic [WAW-1:0]    held_addr,
   input  logic [LANES-1:0]  held_be,
   input  logic [DATA_W-1:0] held_data,
   input  logic [DATA_W-1:0] sram_rdata,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);
   logic [LANES-1:0]  fwd_mask;
   logic [DATA_W-1:0] fwd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid   <= 1'b0;
         fwd_mask <= '0;
         fwd_data <= '0;
      end else begin
         rvalid <= rd_fire;
         if (rd_fire) begin
            fwd_mask <= (held && held_addr == rd_addr) ? held_be : '0;
            fwd_data <= held_data;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_mrg
      assign rdata[8*i+:8] = fwd_mask[i] ? fwd_data[8*i+:8] : sram_rdata[8*i+:8];
   end
endmodule

// File: rtl/sram_post_buffer.sv
module sram_post_buffer #(
   parameter int ADDR_W = 12,
   parameter int LANES  = 4,
   localparam int DATA_W = 8 * LANES,
   localparam int OFF_W  = $clog2(LANES),
   localparam int WAW    = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [1:0]        bus_size,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic [WAW-1:0]    sram_addr,
   output logic [DATA_W-1:0] sram_wdata,
   output logic [LANES-1:0]  sram_be,
   output logic              sram_we,
   input  logic [DATA_W-1:0] sram_rdata
);
   if (LANES != 4) begin : g_bad_lanes
      $error("sram_post_buffer: LANES must be 4 (byte, halfword, word)");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("sram_post_buffer: ADDR_W too small");
   end

   logic [WAW-1:0]    bus_waddr;
   logic [LANES-1:0]  new_be;
   logic [DATA_W-1:0] new_data;
   logic              held;
   logic [WAW-1:0]    held_addr;
   logic [LANES-1:0]  held_be;
   logic [DATA_W-1:0] held_data;
   logic              rd_fire;

   assign bus_waddr = bus_addr[ADDR_W-1:OFF_W];
   assign rd_fire   = bus_rd && !bus_wr;

   spb_lane_map #(.LANES(LANES)) u_map (
      .size      (bus_size),
      .off       (bus_addr[OFF_W-1:0]),
      .wdata     (bus_wdata),
      .be        (new_be),
      .lane_data (new_data)
   );

   spb_hold #(.WAW(WAW), .LANES(LANES)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (bus_wr),
      .in_addr   (bus_waddr),
      .in_be     (new_be),
      .in_data   (new_data),
      .held      (held),
      .held_addr (held_addr),
      .held_be   (held_be),
      .held_data (held_data)
   );

   spb_read_merge #(.WAW(WAW), .LANES(LANES)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_fire    (rd_fire),
      .rd_addr    (bus_waddr),
      .held       (held),
      .held_addr  (held_addr),
      .held_be    (held_be),
      .held_data  (held_data),
      .sram_rdata (sram_rdata),
      .rvalid     (bus_rvalid),
      .rdata      (bus_rdata)
   );

   always_comb begin
      sram_wdata = held_data;
      if (bus_wr) begin
         sram_we   = held;
         sram_addr = held_addr;
         sram_be   = held_be & {LANES{held}};
      end else begin
         sram_we   = 1'b0;
         sram_addr = bus_waddr;
         sram_be   = '0;
      end
   end
endmodule

// File: rtl/spb_chk.sv
module spb_chk #(
   parameter int ADDR_W = 12,
   parameter int LANES  = 4,
   localparam int OFF_W = $clog2(LANES),
   localparam int WAW   = ADDR_W - OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_rvalid,
   input logic [WAW-1:0]    sram_addr,
   input logic              sram_we
);
   logic           pend;
   logic [WAW-1:0] last_waddr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         last_waddr <= '0;
      end else if (bus_wr) begin
         pend       <= 1'b1;
         last_waddr <= bus_addr[ADDR_W-1:OFF_W];
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!sram_we && !bus_rvalid));

   // R2
   commit_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && pend) |-> (sram_we && sram_addr == last_waddr));

   // R3
   first_write_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !pend) |-> !sram_we);

   // R5
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |-> !sram_we);

   // R6
   read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr) |=> bus_rvalid);

   // R7
   collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_rvalid);

   // R10
   read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr) |-> (sram_addr == bus_addr[ADDR_W-1:OFF_W]));
endmodule

bind sram_post_buffer spb_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rvalid (bus_rvalid),
   .sram_addr  (sram_addr),
   .sram_we    (sram_we)
);

// File: tb/sram_post_buffer_test.sv
module sram_post_buffer_test;
   localparam int AW = 12;
   localparam int NV = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [1:0]  bus_size;
   logic        bus_wr, bus_rd;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [9:0]  sram_addr;
   logic [31:0] sram_wdata;
   logic [3:0]  sram_be;
   logic        sram_we;
   logic [31:0] sram_rdata;
   logic [31:0] mem [0:1023];

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;

   sram_post_buffer #(.ADDR_W(AW), .LANES(4)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .sram_addr(sram_addr),
      .sram_wdata(sram_wdata), .sram_be(sram_be), .sram_we(sram_we),
      .sram_rdata(sram_rdata)
   );

   always @(posedge clk) begin
      if (sram_we) begin
         for (int l = 0; l < 4; l++)
            if (sram_be[l]) mem[sram_addr][8*l+:8] <= sram_wdata[8*l+:8];
      end else begin
         sram_rdata <= mem[sram_addr];
      end
   end

   // op[126:125] size[124:123] addr[122:111] data[110:79]
   // exp_we[78] exp_waddr[77:68] exp_be[67:64] exp_wd[63:32] exp_rd[31:0]
   localparam logic [126:0] VEC [0:NV-1] = '{
      {2'd1, 2'd0, 12'h010, 32'h000000AB, 1'b0, 10'd0,  4'h0, 32'h0,        32'h0},
      {2'd1, 2'd1, 12'h022, 32'h00001234, 1'b1, 10'd4,  4'h1, 32'h000000AB, 32'h0},
      {2'd2, 2'd2, 12'h020, 32'h0,        1'b0, 10'd0,  4'h0, 32'h0,        32'h12340008},
      {2'd2, 2'd2, 12'h010, 32'h0,        1'b0, 10'd0,  4'h0, 32'h0,        32'h111100AB},
      {2'd1, 2'd2, 12'h033, 32'hDEADBEEF, 1'b1, 10'd8,  4'hC, 32'h12340000, 32'h0},
      {2'd1, 2'd0, 12'h031, 32'h00000077, 1'b1, 10'd12, 4'hF, 32'hDEADBEEF, 32'h0},
      {2'd2, 2'd2, 12'h030, 32'h0,        1'b0, 10'd0,  4'h0, 32'h0,        32'hDEAD77EF},
      {2'd3, 2'd1, 12'h041, 32'h0000CAFE, 1'b1, 10'd12, 4'h2, 32'h00007700, 32'h0},
      {2'd2, 2'd2, 12'h030, 32'h0,        1'b0, 10'd0,  4'h0, 32'h0,        32'hDEAD77EF},
      {2'd1, 2'd3, 12'h050, 32'h01020304, 1'b1, 10'd16, 4'h3, 32'h0000CAFE, 32'h0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input bit w, input bit r, input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_size = sz; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 2'd0, 12'h0, 32'h0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 4000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         finish_run();
      end
   end

   initial begin
      logic [1:0]  prev_op;
      logic [31:0] prev_rd;
      for (int i = 0; i < 1024; i++) mem[i] = 32'h11110000 + i;
      sram_rdata = '0;
      rst_n = 1'b0;
      bus_wr = 1'b1; bus_rd = 1'b1; bus_size = 2'd2; bus_addr = 12'h100; bus_wdata = 32'hFFFFFFFF;
      @(negedge clk);
      #5;
      // R1: reset holds the SRAM write enable and read-valid low
      chk(!sram_we, "R1 we in reset", {31'd0, sram_we}, 32'd0);
      chk(!bus_rvalid, "R1 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      bus_wr = 1'b0; bus_rd = 1'b0;

      prev_op = 2'd0;
      prev_rd = '0;
      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [11:0] a;
         op = VEC[v][126:125];
         a  = VEC[v][122:111];
         drive(op[0], op[1], VEC[v][124:123], a, VEC[v][110:79]);
         // read response of previous row (R6, R7)
         chk(bus_rvalid == (prev_op == 2'd2), "R6/R7 rvalid", {31'd0, bus_rvalid}, {31'd0, prev_op == 2'd2});
         if (prev_op == 2'd2)
            chk(bus_rdata == prev_rd, "R6 merged read data", bus_rdata, prev_rd);
         #5;
         if (op[0]) begin
            if (VEC[v][78]) begin
               // R2 commit of the held write, R4 lane mapping
               chk(sram_we, "R2 commit we", {31'd0, sram_we}, 32'd1);
               chk(sram_addr == VEC[v][77:68], "R2 commit addr", {22'd0, sram_addr}, {22'd0, VEC[v][77:68]});
               chk(sram_be == VEC[v][67:64], "R4 byte enables", {28'd0, sram_be}, {28'd0, VEC[v][67:64]});
               chk((sram_wdata & {{8{sram_be[3]}}, {8{sram_be[2]}}, {8{sram_be[1]}}, {8{sram_be[0]}}}) == VEC[v][63:32],
                   "R4 lane data", sram_wdata, VEC[v][63:32]);
            end else begin
               chk(!sram_we, "R3 first write held", {31'd0, sram_we}, 32'd0);
            end
         end else begin
            chk(!sram_we, "R5 no write on read", {31'd0, sram_we}, 32'd0);
            chk(sram_addr == a[11:2], "R10 read address", {22'd0, sram_addr}, {22'd0, a[11:2]});
         end
         prev_op = op;
         prev_rd = VEC[v][31:0];
      end
      idle();

      // R8: reset drops the held word-20 write
      @(negedge clk);
      rst_n = 1'b0;
      bus_wr = 1'b1; bus_addr = 12'h080; bus_size = 2'd2; bus_wdata = 32'h0;
      #5;
      chk(!sram_we, "R1 we with strobe in reset", {31'd0, sram_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      bus_wr = 1'b0;
      chk(mem[20] == 32'h11110014, "R8 held write lost", mem[20], 32'h11110014);
      drive(1'b0, 1'b1, 2'd2, 12'h050, 32'h0);
      idle();
      chk(bus_rvalid && bus_rdata == 32'h11110014, "R8 read after reset", bus_rdata, 32'h11110014);

      // R9: double write survives reset
      drive(1'b1, 1'b0, 2'd2, 12'h060, 32'h55AA55AA);
      idle();
      chk(mem[24] == 32'h11110018, "R3 single write not in SRAM", mem[24], 32'h11110018);
      drive(1'b1, 1'b0, 2'd2, 12'h060, 32'h55AA55AA);
      idle();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(mem[24] == 32'h55AA55AA, "R9 repeated write kept", mem[24], 32'h55AA55AA);

      // R2: a throwaway write elsewhere commits the held one
      drive(1'b1, 1'b0, 2'd2, 12'h070, 32'h0BADF00D);
      drive(1'b1, 1'b0, 2'd0, 12'h3FC, 32'h0);
      idle();
      chk(mem[28] == 32'h0BADF00D, "R2 dummy write commits", mem[28], 32'h0BADF00D);
      chk(mem[255] == 32'h111100FF, "R2 dummy write still held", mem[255], 32'h111100FF);

      done = 1'b1;
      finish_run();
   end
endmodule